// File: doc/BRIEF.md
# Six-Step Multiply-Accumulate Sequencer with Early Output Observation

The block runs a fixed six-step schedule over a 16-bit datapath. A start pulse captures a first operand from the data input. The single multiplier then forms three chained products: the captured operand times an input word, that product times another input word, and that product times a fixed constant. A separate input register takes words from the data input. The adder sums that register with either the live multiplier result (in the multiplying steps) or the stored product (afterwards). The adder result goes into the output register, which drives the output port.

In functional operation the output register loads only in the last two steps. Its load enable in steps 2 and 3 has no effect on the functional result, so the controller is free to set it there. With the test mode input high, the controller does set it in those steps, which makes the second and third products (plus the input-register word) visible at the output port with no added datapath hardware. Every other control signal is the same in both modes, so the final result does not depend on the mode.

Top module: `obs_sched_top`

## Requirements
- R1: While reset is asserted, and after its release until the first start, `dout` is 0, `done` is 0 and the controller is idle.
- R2: A `start` high in an idle cycle captures `din` as operand A and launches step 1 on the next cycle. Steps 1 to 6 follow on consecutive cycles. `done` is high for exactly the one cycle after step 6, after which the controller is idle again.
- R3: With `test_mode` low, `dout` keeps its value through idle and steps 1 to 4.
- R4: Products are truncated to 16 bits. P1 = A·D1 is formed in step 1, P2 = P1·D2 in step 2 and P3 = P2·K in step 3, where Dn is `din` during step n and K is the constant parameter (default 5).
- R5: The input register takes D1 in step 1, D4 in step 4 and D5 in step 5. At the end of step 5, `dout` becomes (P3 + D4) mod 2^16. At the end of step 6 it becomes (P3 + D5) mod 2^16.
- R6: With `test_mode` high, `dout` also loads at the end of step 2 with (P2 + D1) mod 2^16 and at the end of step 3 with (P3 + D1) mod 2^16. These values are visible during steps 3 and 4 respectively.
- R7: The value of `dout` after step 6 is the same for the same inputs whatever `test_mode` was during the run.
- R8: `start` has no effect outside the idle state: a run in progress is neither restarted nor stretched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Launches a run when the controller is idle |
| test_mode | input | 1 | Enables output-register loads in steps 2 and 3 |
| din | input | 16 | Operand and addend input word |
| dout | output | 16 | Output register contents |
| done | output | 1 | One-cycle flag after step 6 |

## Verification
The hardest behaviour to reach from the ports is the intermediate product P2. In functional mode it never reaches `dout`, and its effect is hidden behind the constant multiply in step 3. The stimulus therefore runs each operand set twice, once with `test_mode` high so that P2 plus D1 becomes visible during step 3, and once with it low to confirm that the final value agrees. Operands near 0xFFFF make the truncation of every product and sum show up. One run holds `start` high through a whole run to show that no restart happens.

// File: rtl/obs_sched_pkg.sv
package obs_sched_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_S1   = 3'd1,
    ST_S2   = 3'd2,
    ST_S3   = 3'd3,
    ST_S4   = 3'd4,
    ST_S5   = 3'd5,
    ST_S6   = 3'd6,
    ST_FIN  = 3'd7
  } step_t;

  typedef struct packed {
    logic ld_a;        // capture operand A from din
    logic ld_p;        // capture multiplier result
    logic ld_in;       // capture din into input register
    logic ld_out;      // capture adder result into output register
    logic opa_from_a;  // multiplier left operand: A register (else product register)
    logic opb_from_k;  // multiplier right operand: constant (else din)
    logic add_from_mul;// adder operand: live multiplier result (else product register)
    logic done;
  } ctl_t;

endpackage

// File: rtl/obs_sched_ctrl.sv
module obs_sched_ctrl
  import obs_sched_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  logic  test_mode,
  output step_t step,
  output ctl_t  ctl
);

  step_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_S1;
      ST_S1:   state_d = ST_S2;
      ST_S2:   state_d = ST_S3;
      ST_S3:   state_d = ST_S4;
      ST_S4:   state_d = ST_S5;
      ST_S5:   state_d = ST_S6;
      ST_S6:   state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // Functional schedule; the output load in steps 2 and 3 is a free choice
  // in functional terms and is taken only under test_mode.
  always_comb begin
    ctl = '0;
    unique case (state_q)
      ST_IDLE: ctl.ld_a = start;
      ST_S1: begin
        ctl.ld_p         = 1'b1;
        ctl.ld_in        = 1'b1;
        ctl.opa_from_a   = 1'b1;
        ctl.add_from_mul = 1'b1;
      end
      ST_S2: begin
        ctl.ld_p         = 1'b1;
        ctl.add_from_mul = 1'b1;
        ctl.ld_out       = test_mode;
      end
      ST_S3: begin
        ctl.ld_p         = 1'b1;
        ctl.opb_from_k   = 1'b1;
        ctl.add_from_mul = 1'b1;
        ctl.ld_out       = test_mode;
      end
      ST_S4: ctl.ld_in = 1'b1;
      ST_S5: begin
        ctl.ld_out = 1'b1;
        ctl.ld_in  = 1'b1;
      end
      ST_S6:  ctl.ld_out = 1'b1;
      ST_FIN: ctl.done   = 1'b1;
      default: ctl = '0;
    endcase
  end

  assign step = state_q;

endmodule

// File: rtl/obs_sched_dp.sv
module obs_sched_dp
  import obs_sched_pkg::*;
#(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] K = 16'd5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  ctl_t         ctl,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] a_q, p_q, in_q, out_q;
  logic [W-1:0] opa, opb, prod, add_b, sum;

  assign opa   = ctl.opa_from_a   ? a_q : p_q;
  assign opb   = ctl.opb_from_k   ? K   : din;
  assign prod  = opa * opb;
  assign add_b = ctl.add_from_mul ? prod : p_q;
  assign sum   = add_b + in_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) a_q <= '0;
    else if (ctl.ld_a) a_q <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) p_q <= '0;
    else if (ctl.ld_p) p_q <= prod;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_q <= '0;
    else if (ctl.ld_in) in_q <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else if (ctl.ld_out) out_q <= sum;
  end

  assign dout = out_q;

endmodule

// File: rtl/obs_sched_top.sv
module obs_sched_top
  import obs_sched_pkg::*;
#(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] K = 16'd5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         test_mode,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         done
);

  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_n_int;
  step_t                  step;
  ctl_t                   ctl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n_int = rst_pipe[SYNC_STAGES-1];

  obs_sched_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .start     (start),
    .test_mode (test_mode),
    .step      (step),
    .ctl       (ctl)
  );

  obs_sched_dp #(.W(W), .K(K)) u_dp (
    .clk   (clk),
    .rst_n (rst_n_int),
    .ctl   (ctl),
    .din   (din),
    .dout  (dout)
  );

  assign done = ctl.done;

endmodule

// File: rtl/obs_sched_chk.sv
module obs_sched_chk
  import obs_sched_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         test_mode,
  input logic [W-1:0] dout,
  input logic         done,
  input step_t        step
);

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_to_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (step == ST_IDLE));

  assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_IDLE && start) |=> (step == ST_S1));

  assert_hold_func_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_mode && step != ST_IDLE && step <= ST_S4) |=> $stable(dout));

  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_IDLE) |=> $stable(dout));

  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && step != ST_IDLE && step != ST_FIN) |=> (step != ST_S1));

  assert_done_when_fin_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_S6) |=> done);

endmodule

bind obs_sched_top obs_sched_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .test_mode (test_mode),
  .dout      (dout),
  .done      (done),
  .step      (step)
);

// File: tb/obs_sched_top_test.sv
module obs_sched_top_test;

  localparam int  W     = 16;
  localparam int  KVAL  = 5;
  localparam longint MASK = 64'hFFFF;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         test_mode = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout;
  logic         done;

  int checks = 0;
  int fails  = 0;

  // behavioural reference state
  int     m_step = 0;
  longint m_a = 0, m_p = 0, m_in = 0, m_out = 0;
  logic   m_done = 1'b0;

  always #10 clk = ~clk;

  obs_sched_top uut (
    .clk(clk), .rst_n(rst_n), .start(start), .test_mode(test_mode),
    .din(din), .dout(dout), .done(done)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive one cycle at a falling edge, advance model, check at next falling edge.
  task automatic tick(input logic s, input longint d, input logic tm, input string tag);
    longint prod;
    start = s; din = W'(d); test_mode = tm;
    case (m_step)
      0: if (s) begin m_a = d; m_step = 1; end
      1: begin m_p = (m_a * d) & MASK; m_in = d; m_step = 2; end
      2: begin prod = (m_p * d) & MASK;
               if (tm) m_out = (prod + m_in) & MASK;
               m_p = prod; m_step = 3; end
      3: begin prod = (m_p * KVAL) & MASK;
               if (tm) m_out = (prod + m_in) & MASK;
               m_p = prod; m_step = 4; end
      4: begin m_in = d; m_step = 5; end
      5: begin m_out = (m_p + m_in) & MASK; m_in = d; m_step = 6; end
      6: begin m_out = (m_p + m_in) & MASK; m_step = 7; end
      default: m_step = 0;
    endcase
    m_done = (m_step == 7);
    @(posedge clk);
    @(negedge clk);
    check({tag, " dout"}, longint'(dout), m_out);
    check({tag, " done"}, longint'(done), longint'(m_done));
  endtask

  // A full run: idle start cycle, six steps, done cycle.
  task automatic run(input longint a, input longint d1, input longint d2,
                     input longint d4, input longint d5, input logic tm,
                     input logic hold_start, input string tag);
    tick(1'b1, a, tm, tag);
    tick(hold_start, d1, tm, tag);
    tick(hold_start, d2, tm, tag);
    tick(hold_start, 16'h1234, tm, tag);
    tick(hold_start, d4, tm, tag);
    tick(hold_start, d5, tm, tag);
    tick(hold_start, 16'h4321, tm, tag);
    tick(1'b0, 0, tm, tag);
  endtask

  initial begin
    longint final_func;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 dout in reset", longint'(dout), 0);
    check("R1 done in reset", longint'(done), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 dout after release", longint'(dout), 0);
    check("R1 done after release", longint'(done), 0);
    // R1 / R3: idle cycles with activity on din and no start
    for (int i = 0; i < 3; i++) tick(1'b0, 16'hBEEF + i, 1'b0, "R1 idle");

    // R2 R3 R4 R5: functional run
    run(3, 7, 11, 100, 200, 1'b0, 1'b0, "R5 func");
    final_func = m_out;
    check("R5 final functional value", longint'(dout), ((3*7*11*KVAL) + 200) & MASK);

    // R6: same operands with test mode, intermediate products seen
    run(3, 7, 11, 100, 200, 1'b1, 1'b0, "R6 test");
    // R7: final result independent of mode
    check("R7 final equal across modes", longint'(dout), final_func);

    // R4: truncation with large operands, both modes
    run(16'hFFFF, 16'hFFFE, 16'h8001, 16'hFFFF, 16'hF0F0, 1'b0, 1'b0, "R4 wide func");
    final_func = m_out;
    run(16'hFFFF, 16'hFFFE, 16'h8001, 16'hFFFF, 16'hF0F0, 1'b1, 1'b0, "R4 wide test");
    check("R7 wide final equal across modes", longint'(dout), final_func);

    // R8: start held high through a whole run
    run(9, 13, 17, 5, 6, 1'b0, 1'b1, "R8 start held");
    // R8 back-to-back: launch immediately again after idle return
    run(2, 4, 6, 8, 10, 1'b1, 1'b1, "R8 back to back");

    // R3: functional run leaves dout untouched until step 5
    run(21, 22, 23, 24, 25, 1'b0, 1'b0, "R3 hold");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule